// File: doc/BRIEF.md
# Framed Synchronous Serial Master

This block drives a synchronous serial link in which every character is announced by a single positive pulse on a frame line. The pulse is one serial clock period wide. The block then shifts the character out on the data output and shifts the reply in on the data input at the same time. A client hands over transmit characters through a valid/ready port. Each received character comes back on a one-cycle valid strobe. Character length, bit order and the serial clock divider are taken from configuration inputs when a character is accepted, so each character may use its own settings.

The serial clock runs only while characters are moving and rests low otherwise. Outgoing bits change on the serial clock rising edge and incoming bits are captured on the falling edge. The data output keeps the final bit of the last character while the link rests. A character offered during the ready window of the current one is chained directly: its frame pulse lands in the last bit period of the current character, and no idle gap appears on the link.

Top module: `ssf_master`

## Requirements
- R1: After reset, ser_clk, ser_frm, ser_dout and rx_valid are 0 and tx_ready is 1.
- R2: Each character starts with ser_frm high for exactly one serial period, which is 2*(cfg_div+1) system clocks. ser_frm rises and falls only in cycles where ser_clk rises.
- R3: ser_dout changes only in cycles where ser_clk rises.
- R4: Received bits are the ser_din values present at the system clock edges where ser_clk falls, one per data bit period.
- R5: With cfg_lsb_first=0, bit len-1 of tx_data goes out first; with cfg_lsb_first=1, bit 0 goes out first. Received characters are assembled in the same order into rx_data bits len-1..0, and the bits above are zero.
- R6: The character length is cfg_len clamped into 4..16: values below 4 act as 4, and values above 16 act as 16.
- R7: After the last bit of a character, ser_dout holds that bit's value until the next character's first bit.
- R8: ser_clk toggles only while characters are in flight, each half period lasts cfg_div+1 system clocks, and ser_clk and ser_frm are low while idle.
- R9: A character accepted during the ready window of a running character gets its frame pulse in that character's last bit period, so the two frame pulses are len*2*(cfg_div+1) system clocks apart.
- R10: rx_valid is a single-cycle pulse that rises one system clock after the edge that captures the last bit.
- R11: tx_ready is 1 while idle. While busy it is 1 only in the cycle before the last bit period starts, and only when no chained character is held.
- R12: Configuration inputs and tx_data are sampled only at the handshake, so changing them mid-character does not alter that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | 5 | Requested character length in bits |
| cfg_lsb_first | input | 1 | 1: least significant bit first; 0: most significant first |
| cfg_div | input | 8 | Half period of the serial clock minus one, in system clocks |
| tx_data | input | 16 | Character to send, right aligned |
| tx_valid | input | 1 | A transmit character is offered |
| tx_ready | output | 1 | The offered character is taken at this edge |
| rx_data | output | 16 | Last received character, right aligned |
| rx_valid | output | 1 | One-cycle strobe marking a new rx_data |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_frm | output | 1 | One-period frame pulse before each character |
| ser_dout | output | 1 | Serial data out |
| ser_din | input | 1 | Serial data in |

## Verification
A wrong bit index or bit-order state shows on ser_dout within one serial period of the fault. It also appears in the captured word that the bench compares once the character ends. A corrupt receive shift state shows in rx_data one system clock after the final falling edge. A sequencer that loses track of the period count shows as a frame pulse of the wrong width, a gap or overlap between chained characters, or ser_clk still toggling in the first idle cycles after the last bit.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } link_state_e;

  function automatic logic [7:0] fit_len(input logic [7:0] req,
                                         input logic [7:0] lo,
                                         input logic [7:0] hi);
    if (req < lo)      return lo;
    else if (req > hi) return hi;
    else               return req;
  endfunction

endpackage

// File: rtl/ssf_clkgen.sv
// Serial clock generator: half periods of div+1 system clocks, with
// rise/fall event strobes for the sequencer.
module ssf_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             halt,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt,
  output logic             active
);

  logic [DIV_W-1:0] hcnt;
  logic             at_end;

  assign at_end   = (hcnt == div);
  assign rise_evt = active & ~sclk & at_end;
  assign fall_evt = active &  sclk & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      sclk   <= 1'b0;
      hcnt   <= '0;
    end else if (start) begin
      active <= 1'b1;
      sclk   <= 1'b1;
      hcnt   <= '0;
    end else if (active) begin
      if (at_end) begin
        hcnt <= '0;
        if (sclk)      sclk   <= 1'b0;
        else if (halt) active <= 1'b0;
        else           sclk   <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssf_txpath.sv
// Transmit shifter: on each shift event emits the next bit in the
// selected order; 'first' takes a fresh word instead of the shifter.
module ssf_txpath #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_evt,
  input  logic              first,
  input  logic [DATA_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              lsb_first,
  output logic              dt
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] src;
  logic [IDX_W-1:0]  top_idx;
  logic              next_bit;

  always_comb begin
    src      = first ? word : sh;
    top_idx  = IDX_W'(len - 1'b1);
    next_bit = lsb_first ? src[0] : src[top_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '0;
      dt <= 1'b0;
    end else if (shift_evt) begin
      dt <= next_bit;
      sh <= lsb_first ? (src >> 1) : (src << 1);
    end
  end

endmodule

// File: rtl/ssf_rxpath.sv
// Receive shifter: captures one bit per sample event, assembles it in
// the selected order and strobes the finished word one clock later.
module ssf_rxpath #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_evt,
  input  logic              first,
  input  logic              last,
  input  logic              din,
  input  logic [LEN_W-1:0]  len,
  input  logic              lsb_first,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] sh_next;
  logic [IDX_W-1:0]  top_idx;
  logic              done;

  always_comb begin
    src     = first ? '0 : sh;
    top_idx = IDX_W'(len - 1'b1);
    if (lsb_first) sh_next = (src >> 1) | (DATA_W'(din) << top_idx);
    else           sh_next = (src << 1) | DATA_W'(din);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      done     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (sample_evt) sh <= sh_next;
      done     <= sample_evt & last;
      rx_valid <= done;
      if (done) rx_data <= sh;
    end
  end

endmodule

// File: rtl/ssf_master.sv
// Framed synchronous serial master: period sequencer plus clock,
// transmit and receive sub-blocks.
module ssf_master
  import ssf_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MIN_LEN = 4,
  parameter int DIV_W   = 8,
  localparam int LEN_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_lsb_first,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              ser_clk,
  output logic              ser_frm,
  output logic              ser_dout,
  input  logic              ser_din
);

  link_state_e       state;
  logic              busy;
  logic [LEN_W-1:0]  pidx;      // 0: frame period, 1..len: data bits
  logic              pend;
  logic              frm_q;
  logic [LEN_W-1:0]  cur_len;
  logic              cur_lsb;
  logic [DIV_W-1:0]  cur_div;
  logic [DATA_W-1:0] nxt_word;
  logic [LEN_W-1:0]  nxt_len;
  logic              nxt_lsb;
  logic [DIV_W-1:0]  nxt_div;

  logic [LEN_W-1:0]  in_len;
  logic [LEN_W-1:0]  pen_idx;
  logic              rise_evt, fall_evt, clk_active;
  logic              in_last, start_new, halt, take_run, shift_evt;
  logic              sample_evt;
  logic [LEN_W-1:0]  tx_len;
  logic              tx_lsb;

  assign busy    = (state == ST_RUN);
  assign in_len  = LEN_W'(fit_len(8'(cfg_len), 8'(MIN_LEN), 8'(DATA_W)));
  assign pen_idx = LEN_W'(cur_len - 1'b1);

  always_comb begin
    in_last    = (pidx == cur_len);
    start_new  = rise_evt & ((pidx == '0) | (in_last & pend));
    halt       = in_last & ~pend;
    take_run   = rise_evt & (pidx == pen_idx) & ~pend;
    shift_evt  = rise_evt & ~halt;
    sample_evt = fall_evt & (pidx != '0);
    tx_ready   = ~busy | take_run;
    tx_len     = start_new ? nxt_len : cur_len;
    tx_lsb     = start_new ? nxt_lsb : cur_lsb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      pidx     <= '0;
      pend     <= 1'b0;
      frm_q    <= 1'b0;
      cur_len  <= LEN_W'(MIN_LEN);
      cur_lsb  <= 1'b0;
      cur_div  <= '0;
      nxt_word <= '0;
      nxt_len  <= LEN_W'(MIN_LEN);
      nxt_lsb  <= 1'b0;
      nxt_div  <= '0;
    end else if (!busy) begin
      if (tx_valid) begin
        state    <= ST_RUN;
        pidx     <= '0;
        frm_q    <= 1'b1;
        cur_len  <= in_len;
        cur_lsb  <= cfg_lsb_first;
        cur_div  <= cfg_div;
        nxt_word <= tx_data;
        nxt_len  <= in_len;
        nxt_lsb  <= cfg_lsb_first;
        nxt_div  <= cfg_div;
      end
    end else if (rise_evt) begin
      if (start_new) begin
        pidx    <= LEN_W'(1);
        frm_q   <= 1'b0;
        pend    <= 1'b0;
        cur_len <= nxt_len;
        cur_lsb <= nxt_lsb;
        cur_div <= nxt_div;
      end else if (halt) begin
        state <= ST_IDLE;
        frm_q <= 1'b0;
      end else begin
        pidx <= pidx + 1'b1;
        if (take_run && tx_valid) begin
          pend     <= 1'b1;
          frm_q    <= 1'b1;
          nxt_word <= tx_data;
          nxt_len  <= in_len;
          nxt_lsb  <= cfg_lsb_first;
          nxt_div  <= cfg_div;
        end
      end
    end
  end

  assign ser_frm = frm_q;

  ssf_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .start    (~busy & tx_valid),
    .halt     (halt),
    .div      (cur_div),
    .sclk     (ser_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .active   (clk_active)
  );

  ssf_txpath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .shift_evt (shift_evt),
    .first     (start_new),
    .word      (nxt_word),
    .len       (tx_len),
    .lsb_first (tx_lsb),
    .dt        (ser_dout)
  );

  ssf_rxpath #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .sample_evt (sample_evt),
    .first      (pidx == LEN_W'(1)),
    .last       (in_last),
    .din        (ser_din),
    .len        (cur_len),
    .lsb_first  (cur_lsb),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid)
  );

endmodule

// File: rtl/ssf_master_chk.sv
module ssf_master_chk (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic frm,
  input logic dt,
  input logic tx_ready,
  input logic rx_valid,
  input logic busy,
  input logic clk_active,
  input logic pend
);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclk && !frm));

  p_gen_sync_r8: assert property (@(posedge clk) disable iff (rst)
    busy == clk_active);

  p_dt_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(dt) |-> $rose(sclk));

  p_frm_up_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(frm) |-> $rose(sclk));

  p_frm_down_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(frm) |-> $rose(sclk));

  p_rxv_single_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_rxv_after_fall_r10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(sclk, 2) && !$past(sclk)));

  p_ready_window_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && busy) |-> !pend);

  p_chain_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    pend |-> frm);

endmodule

bind ssf_master ssf_master_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sclk       (ser_clk),
  .frm        (ser_frm),
  .dt         (ser_dout),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .busy       (busy),
  .clk_active (clk_active),
  .pend       (pend)
);

// File: tb/ssf_master_tb.sv
module ssf_master_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_len = 5'd8;
  logic        cfg_lsb_first = 1'b0;
  logic [7:0]  cfg_div = 8'd0;
  logic [15:0] tx_data = 16'h0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [15:0] rx_data;
  logic        rx_valid;
  logic        ser_clk, ser_frm, ser_dout;
  logic        ser_din = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ssf_master u_dut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
    .cfg_div(cfg_div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .ser_clk(ser_clk), .ser_frm(ser_frm), .ser_dout(ser_dout),
    .ser_din(ser_din)
  );

  // {len 5, lsb_first 1, div 8, tx 16, din word 16}
  localparam logic [45:0] VEC [8] = '{
    {5'd8,  1'b0, 8'd1, 16'h00A5, 16'h003C},
    {5'd8,  1'b1, 8'd0, 16'h0001, 16'h0080},
    {5'd16, 1'b0, 8'd2, 16'hBEEF, 16'h1234},
    {5'd4,  1'b1, 8'd0, 16'h000D, 16'h0006},
    {5'd12, 1'b0, 8'd3, 16'hFABC, 16'h0F0F},
    {5'd2,  1'b0, 8'd0, 16'h0009, 16'h0005},
    {5'd31, 1'b1, 8'd1, 16'h8001, 16'hC003},
    {5'd5,  1'b0, 8'd0, 16'h0015, 16'h000A}
  };

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // character bookkeeping shared with the link model
  logic [4:0]  ch_w   [16] = '{default: 5'd4};
  logic        ch_lsb [16] = '{default: 1'b0};
  logic [15:0] ch_dr  [16] = '{default: 16'h0};
  logic [15:0] ch_tx  [16] = '{default: 16'h0};
  int          nq = 0;
  int          exp_half = 1;

  // link model state, written only by the monitor
  logic [15:0] cap [16] = '{default: 16'h0};
  logic [15:0] rxg [16] = '{default: 16'h0};
  int sc = 0, rc = 0, bidx = -1, nfr = 0;
  int frm_len = 0, last_frm_len = 0, hi_run = 0, hi_bad = 0;
  int fall_cyc = 0, rxv_bad = 0, dt_bad = 0;
  int frm_rise_cyc [16] = '{default: 0};
  bit armed = 1'b0;
  logic sclk_q = 1'b0, frm_q = 1'b0, dt_q = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ser_dout !== dt_q && !(ser_clk && !sclk_q)) dt_bad++;
      if (ser_clk && !sclk_q) begin
        if (armed) bidx = 0;
        else if (bidx >= 0) bidx++;
        if (bidx >= 0 && sc < nq && bidx < int'(ch_w[sc])) begin
          automatic int pos = ch_lsb[sc] ? bidx : int'(ch_w[sc]) - 1 - bidx;
          ser_din <= ch_dr[sc][pos];
          cap[sc][pos] = ser_dout;
          if (bidx == int'(ch_w[sc]) - 1) begin
            sc++;
            bidx = -1;
          end
        end
        armed = ser_frm;
      end
      if (!ser_clk && sclk_q) begin
        fall_cyc = cyc;
        if (hi_run != exp_half) hi_bad++;
        hi_run = 0;
      end
      if (ser_clk) hi_run++;
      if (ser_frm && !frm_q) begin
        frm_rise_cyc[nfr] = cyc;
        nfr++;
      end
      if (ser_frm) frm_len++;
      else if (frm_q) begin
        last_frm_len = frm_len;
        frm_len = 0;
      end
      if (rx_valid) begin
        if (cyc - fall_cyc != 1) rxv_bad++;
        rxg[rc] = rx_data;
        rc++;
      end
    end
    sclk_q = ser_clk;
    frm_q  = ser_frm;
    dt_q   = ser_dout;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] eff_len(input logic [4:0] w);
    if (w < 5'd4) return 5'd4;
    if (w > 5'd16) return 5'd16;
    return w;
  endfunction

  function automatic logic [15:0] len_mask(input logic [4:0] w);
    return 16'((32'h1 << w) - 1);
  endfunction

  task automatic send(input logic [4:0] w, input logic lsb, input logic [7:0] dv,
                      input logic [15:0] d, input logic [15:0] drw);
    ch_w[nq] = eff_len(w); ch_lsb[nq] = lsb; ch_dr[nq] = drw; ch_tx[nq] = d;
    nq++;
    @(negedge clk);
    cfg_len = w; cfg_lsb_first = lsb; cfg_div = dv; tx_data = d; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    // scramble inputs after the handshake (R12)
    tx_valid = 1'b0; cfg_len = 5'd9; cfg_lsb_first = ~lsb; cfg_div = 8'd5;
    tx_data = 16'hFFFF;
  endtask

  task automatic wait_done();
    while (rc < nq) @(negedge clk);
    repeat (12) @(negedge clk);
  endtask

  task automatic check_char(input int k, input string rq);
    automatic logic [15:0] m = len_mask(ch_w[k]);
    check((cap[k] & m) == (ch_tx[k] & m), {rq, " R5 R12 tx bits"},
          int'(cap[k] & m), int'(ch_tx[k] & m));
    check(rxg[k] == (ch_dr[k] & m), {rq, " R4 R5 rx word"},
          int'(rxg[k]), int'(ch_dr[k] & m));
  endtask

  task automatic run_all();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ser_clk == 0 && ser_frm == 0 && ser_dout == 0, "R1 pins idle",
          {ser_clk, ser_frm, ser_dout}, 0);
    check(tx_ready == 1 && rx_valid == 0, "R1 handshake idle", {tx_ready, rx_valid}, 2);

    foreach (VEC[i]) begin
      automatic logic [45:0] v = VEC[i];
      automatic int hb = hi_bad, rb = rxv_bad;
      automatic logic [4:0] we = eff_len(v[45:41]);
      automatic logic lastb = v[40] ? v[16 + int'(we) - 1] : v[16];
      exp_half = int'(v[39:32]) + 1;
      send(v[45:41], v[40], v[39:32], v[31:16], v[15:0]);
      wait_done();
      check_char(nq - 1, (i == 5 || i == 6) ? "R6" : "vec");
      check(last_frm_len == 2 * exp_half, "R2 frame width", last_frm_len, 2 * exp_half);
      check(hi_bad == hb, "R8 half period", hi_bad - hb, 0);
      check(rxv_bad == rb, "R10 strobe timing", rxv_bad - rb, 0);
      check(ser_clk == 0 && ser_frm == 0, "R8 idle pins", {ser_clk, ser_frm}, 0);
      check(ser_dout == lastb, "R7 dout holds last bit", ser_dout, lastb);
    end

    // R11: ready drops once a character is running
    exp_half = 4;
    send(5'd8, 1'b0, 8'd3, 16'h0033, 16'h00CC);
    check(tx_ready == 0, "R11 ready low while busy", tx_ready, 0);
    wait_done();
    check_char(nq - 1, "R11");

    // R9: chained pair, no gap between characters
    begin
      automatic int f0;
      exp_half = 2;
      f0 = nfr;
      send(5'd6, 1'b0, 8'd1, 16'h002D, 16'h0015);
      send(5'd6, 1'b1, 8'd1, 16'h0013, 16'h002A);
      wait_done();
      check(nfr - f0 == 2, "R9 two pulses", nfr - f0, 2);
      check(frm_rise_cyc[f0 + 1] - frm_rise_cyc[f0] == 24, "R9 pulse spacing",
            frm_rise_cyc[f0 + 1] - frm_rise_cyc[f0], 24);
      check_char(nq - 2, "R9 first");
      check_char(nq - 1, "R9 second");
      check(ser_dout == 1'b0, "R7 after chain", ser_dout, 0);
    end

    check(dt_bad == 0, "R3 dout edge", dt_bad, 0);
    check(rc == nq, "R10 strobe count", rc, nq);
  endtask

  initial begin
    bit wd = 1'b0;
    fork
      run_all();
      begin
        while (cyc < 150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) check(1'b0, "watchdog", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule